// File: doc/BRIEF.md
# CAN Message Mailbox Bank with Queue Mode

This block holds the message mailboxes of a CAN controller. A host writes and reads whole frames (identifier, IDE and RTR bits, length code and eight data bytes) by mailbox index. It also sets a small per-mailbox control word. On the other side, the protocol engine hands in received frames by target index and takes outgoing queued frames through a valid/pop handshake. Bit timing, arbitration, acceptance-mask arithmetic and interrupts are handled elsewhere.

A configuration write picks one of two layouts. In the flat layout every mailbox is an independent slot. In the queue layout the upper eight mailboxes are taken out of the flat map. Four of them become a transmit queue filled by host writes to the window index 24. The other four become a receive queue drained by host reads of the window index 28. The same write chooses the identifier format for the whole bank: standard only, extended only, or mixed. In mixed format the IDE bit comes from the mailbox itself for flat mailboxes. For the transmit queue it comes from each frame written through the window. For the receive queue it comes from a dedicated configuration bit.

Top module: `can_mbox_bank`

## Requirements
- R1: After a synchronous active-low reset the bank is in the flat layout with standard format. `cfg_err_o`, `txq_ovf` and `rx_overrun_cnt` are zero, both queues report empty and not full, and `txq_valid` is low.
- R2: In the flat layout a host write to any index 0..31 stores the frame, and a read of that index returns it. The frame bus is {IDE[98], RTR[97], ID[96:68], DLC[67:64], DATA[63:0]}.
- R3: In the queue layout, host writes to index 24 enter the transmit queue. `txq_frame` shows the oldest entry and `txq_pop` removes it, in write order across pointer wraparound. Host reads of index 24 return zero.
- R4: In the queue layout, received frames aimed at indices 28..31 enter the receive queue. A host read of index 28 returns the oldest entry, or zero when the queue is empty. A read with `hr_en` high removes that entry.
- R5: `txq_full` is high with four entries and `txq_empty` with none. A window write to a full transmit queue is dropped and sets `txq_ovf`. The flag stays set until the next accepted configuration write.
- R6: A received frame that qualifies for a full receive queue is dropped, and `rx_overrun_cnt` rises by one, saturating.
- R7: A configuration write with format code 2'b11 is discarded as a whole: the format, layout and receive-queue IDE keep their values, and `cfg_err_o` is set. The next accepted write clears `cfg_err_o`.
- R8: A configuration write that changes the layout while either queue holds data is discarded and sets `cfg_err_o`. An accepted layout change resets both queue pointers.
- R9: The IDE bit seen on `hr_frame` and `txq_frame` is 0 under format 2'b00 and 1 under 2'b01. Under 2'b10 it is the stored bit.
- R10: A received frame is kept only if its IDE suits the format. Under 2'b00 it must be 0 and under 2'b01 it must be 1. Under 2'b10 it must equal the target mailbox's stored IDE, or `cfg_rxq_ide` for the receive queue.
- R11: In the queue layout, control writes to indices 24..31 are ignored and control reads there return 0. Entering the queue layout clears those control words, so their mask-enable bits read 0.
- R12: Remote frames (RTR=1) pass through both queues unchanged.
- R13: In the flat layout a received frame is stored in its target mailbox only when that mailbox's control word has enable (bit 0) at 1 and direction (bit 1, 1 = transmit) at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fifo_mode | input | 1 | Requested layout, 1 = queue layout |
| cfg_id_fmt | input | 2 | Requested identifier format |
| cfg_rxq_ide | input | 1 | IDE used by the receive queue in mixed format |
| mode_o | output | 1 | Current layout |
| id_fmt_o | output | 2 | Current identifier format |
| cfg_err_o | output | 1 | Last configuration write was discarded |
| hw_en | input | 1 | Host frame write strobe |
| hw_idx | input | 5 | Host write index |
| hw_frame | input | 99 | Host write frame |
| hr_en | input | 1 | Host read strobe (removes the receive-queue head at the window) |
| hr_idx | input | 5 | Host read index |
| hr_frame | output | 99 | Host read frame, combinational |
| ctl_we | input | 1 | Control word write strobe |
| ctl_idx | input | 5 | Control write index |
| ctl_wdata | input | 3 | Control word {mask_en, dir_tx, enable} |
| ctl_ridx | input | 5 | Control read index |
| ctl_rdata | output | 3 | Control read word |
| rx_push | input | 1 | Received frame strobe from the protocol engine |
| rx_idx | input | 5 | Target index of the received frame |
| rx_frame | input | 99 | Received frame |
| rx_overrun_cnt | output | 8 | Receive-queue overrun count |
| txq_valid | output | 1 | Transmit queue holds a frame |
| txq_frame | output | 99 | Oldest transmit-queue frame |
| txq_pop | input | 1 | Protocol engine takes the oldest frame |
| txq_full | output | 1 | Transmit queue full |
| txq_empty | output | 1 | Transmit queue empty |
| txq_ovf | output | 1 | Transmit-queue overflow, sticky |
| rxq_full | output | 1 | Receive queue full |
| rxq_empty | output | 1 | Receive queue empty |

## Verification
Queue pointers that are wrong show up at once on the flags. They show up on the next read at a window as a frame out of order, a repeated frame or a missing one, so the bench walks both queues past wraparound and compares every head. A configuration register that latched an illegal value would show at the next read as a wrong IDE bit or a refused layout change. The checks therefore look at `id_fmt_o`, `mode_o` and the returned IDE in the cycle after each configuration write. A gating error on indices 24..31 appears directly as a nonzero control read or a stored frame in a slot that should have been skipped.

// File: rtl/can_mbox_pkg.sv
// Shared widths, frame and control types and identifier-format helpers
// for the CAN mailbox bank. Assumes a 29-bit identifier field that also
// carries 11-bit standard identifiers in its low bits.
package can_mbox_pkg;

    localparam int ID_W    = 29;
    localparam int DLC_W   = 4;
    localparam int DATA_W  = 64;
    localparam int FRAME_W = 2 + ID_W + DLC_W + DATA_W;
    localparam int CTL_W   = 3;

    typedef enum logic [1:0] {
        FMT_STD = 2'b00,
        FMT_EXT = 2'b01,
        FMT_MIX = 2'b10,
        FMT_BAD = 2'b11
    } id_fmt_e;

    typedef struct packed {
        logic              ide;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic mask_en;
        logic dir_tx;
        logic enable;
    } mb_ctl_t;

    // IDE bit presented outward for a stored bit under a given format
    function automatic logic eff_ide(id_fmt_e fmt, logic stored);
        case (fmt)
            FMT_STD: return 1'b0;
            FMT_EXT: return 1'b1;
            default: return stored;
        endcase
    endfunction

    // Whether an arriving IDE bit suits the format and the slot's own IDE
    function automatic logic ide_match(id_fmt_e fmt, logic ide, logic slot_ide);
        case (fmt)
            FMT_STD: return !ide;
            FMT_EXT: return ide;
            default: return ide == slot_ide;
        endcase
    endfunction

    // Frame with its IDE bit replaced by the format-dependent value
    function automatic frame_t apply_fmt(frame_t f, id_fmt_e fmt);
        frame_t r;
        r     = f;
        r.ide = eff_ide(fmt, f.ide);
        return r;
    endfunction

endpackage

// File: rtl/can_mbox_cfg.sv
// Configuration register of the mailbox bank: layout bit, identifier
// format and receive-queue IDE. Assumes the caller reports whether both
// queues are empty; a write is accepted whole or discarded whole.
module can_mbox_cfg
    import can_mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_fifo_mode,
    input  logic [1:0] cfg_id_fmt,
    input  logic       cfg_rxq_ide,
    input  logic       queues_empty,
    output logic       mode_q,
    output id_fmt_e    fmt_q,
    output logic       rxq_ide_q,
    output logic       err_q,
    output logic       cfg_ok,
    output logic       flush,
    output logic       enter_fifo
);

    logic fmt_legal;
    logic mode_ok;

    // Decide whether the current write may be taken
    always_comb begin
        fmt_legal  = (id_fmt_e'(cfg_id_fmt) != FMT_BAD);
        mode_ok    = (cfg_fifo_mode == mode_q) || queues_empty;
        cfg_ok     = cfg_we && fmt_legal && mode_ok;
        flush      = cfg_ok && (cfg_fifo_mode != mode_q);
        enter_fifo = flush && cfg_fifo_mode;
    end

    // Hold the configuration and the discarded-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            fmt_q     <= FMT_STD;
            rxq_ide_q <= 1'b0;
            err_q     <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_ok) begin
                mode_q    <= cfg_fifo_mode;
                fmt_q     <= id_fmt_e'(cfg_id_fmt);
                rxq_ide_q <= cfg_rxq_ide;
                err_q     <= 1'b0;
            end else begin
                err_q     <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_mbox_queue.sv
// Small circular frame queue with full and empty flags and a flush.
// Assumes the caller never pushes when full nor pops when empty; DEPTH
// is a power of two.
module can_mbox_queue #(
    parameter int W     = 99,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wr_ptr;
    logic [PW:0]  rd_ptr;

    // Flags from the pointer difference
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
        dout  = mem[rd_ptr[PW-1:0]];
    end

    // Advance the pointers, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Store the pushed frame
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr[PW-1:0]] <= din;
    end

endmodule

// File: rtl/can_mbox_store.sv
// Flat mailbox array with per-mailbox control words. Host writes win
// over received frames in the same cycle. Assumes the top has already
// removed accesses that belong to the queue windows.
module can_mbox_store
    import can_mbox_pkg::*;
#(
    parameter int NUM_MB   = 32,
    parameter int CLR_BASE = 24,
    localparam int IDX_W   = $clog2(NUM_MB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  id_fmt_e              fmt,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  frame_t               wr_frame,
    input  logic                 rx_en,
    input  logic [IDX_W-1:0]     rx_idx,
    input  frame_t               rx_frame,
    input  logic                 ctl_we,
    input  logic [IDX_W-1:0]     ctl_widx,
    input  mb_ctl_t              ctl_wdata,
    input  logic                 clear_upper,
    input  logic [IDX_W-1:0]     rd_idx,
    output frame_t               rd_frame,
    input  logic [IDX_W-1:0]     ctl_ridx,
    output mb_ctl_t              ctl_rdata
);

    frame_t  mb  [NUM_MB];
    mb_ctl_t ctl [NUM_MB];

    // Read both arrays by index
    always_comb begin
        rd_frame  = mb[rd_idx];
        ctl_rdata = ctl[ctl_ridx];
    end

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic rx_take;

        // Received frame qualifies for this mailbox
        always_comb begin
            rx_take = rx_en && (rx_idx == IDX_W'(i)) && ctl[i].enable &&
                      !ctl[i].dir_tx && ide_match(fmt, rx_frame.ide, mb[i].ide);
        end

        // Update the frame held in this mailbox
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mb[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                mb[i] <= wr_frame;
            end else if (rx_take) begin
                mb[i] <= rx_frame;
            end
        end

        // Update this mailbox's control word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl[i] <= '0;
            end else if (clear_upper && (i >= CLR_BASE)) begin
                ctl[i] <= '0;
            end else if (ctl_we && (ctl_widx == IDX_W'(i))) begin
                ctl[i] <= ctl_wdata;
            end
        end
    end

endmodule

// File: rtl/can_mbox_bank.sv
// CAN mailbox bank top: flat mailboxes plus an optional pair of queues
// mapped over the upper mailboxes, reached through two window indices.
// Assumes one host and one protocol-engine access of each kind per cycle.
module can_mbox_bank
    import can_mbox_pkg::*;
#(
    parameter int NUM_MB = 32,
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_fifo_mode,
    input  logic [1:0]         cfg_id_fmt,
    input  logic               cfg_rxq_ide,
    output logic               mode_o,
    output logic [1:0]         id_fmt_o,
    output logic               cfg_err_o,
    input  logic               hw_en,
    input  logic [IDX_W-1:0]   hw_idx,
    input  logic [FRAME_W-1:0] hw_frame,
    input  logic               hr_en,
    input  logic [IDX_W-1:0]   hr_idx,
    output logic [FRAME_W-1:0] hr_frame,
    input  logic               ctl_we,
    input  logic [IDX_W-1:0]   ctl_idx,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic [IDX_W-1:0]   ctl_ridx,
    output logic [CTL_W-1:0]   ctl_rdata,
    input  logic               rx_push,
    input  logic [IDX_W-1:0]   rx_idx,
    input  logic [FRAME_W-1:0] rx_frame,
    output logic [CNT_W-1:0]   rx_overrun_cnt,
    output logic               txq_valid,
    output logic [FRAME_W-1:0] txq_frame,
    input  logic               txq_pop,
    output logic               txq_full,
    output logic               txq_empty,
    output logic               txq_ovf,
    output logic               rxq_full,
    output logic               rxq_empty
);

    localparam int TXQ_BASE = NUM_MB - 2 * QDEPTH;
    localparam int RXQ_BASE = NUM_MB - QDEPTH;
    localparam logic [IDX_W-1:0] TXQ_IDX = IDX_W'(TXQ_BASE);
    localparam logic [IDX_W-1:0] RXQ_IDX = IDX_W'(RXQ_BASE);

    logic    mode_q, rxq_ide_q, cfg_ok, flush, enter_fifo;
    id_fmt_e fmt_q;
    frame_t  rx_f;
    frame_t  st_rd_frame, txq_head, rxq_head;
    mb_ctl_t st_ctl_rdata;
    logic    txq_try, txq_push, txq_pop_ok, st_wr_en;
    logic    rxq_try, rxq_push, rxq_drop, rxq_pop, st_rx_en, st_ctl_we;

    can_mbox_cfg u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_fifo_mode (cfg_fifo_mode),
        .cfg_id_fmt    (cfg_id_fmt),
        .cfg_rxq_ide   (cfg_rxq_ide),
        .queues_empty  (txq_empty && rxq_empty),
        .mode_q        (mode_q),
        .fmt_q         (fmt_q),
        .rxq_ide_q     (rxq_ide_q),
        .err_q         (cfg_err_o),
        .cfg_ok        (cfg_ok),
        .flush         (flush),
        .enter_fifo    (enter_fifo)
    );

    // Route host, engine and control accesses to the store or the queues
    always_comb begin
        rx_f       = frame_t'(rx_frame);
        txq_try    = hw_en && mode_q && (hw_idx == TXQ_IDX);
        txq_push   = txq_try && !txq_full && !flush;
        st_wr_en   = hw_en && !(mode_q && (hw_idx >= TXQ_IDX));
        txq_pop_ok = txq_pop && !txq_empty;
        rxq_try    = rx_push && mode_q && (rx_idx >= RXQ_IDX) &&
                     ide_match(fmt_q, rx_f.ide, rxq_ide_q);
        rxq_push   = rxq_try && !rxq_full && !flush;
        rxq_drop   = rxq_try && rxq_full;
        rxq_pop    = hr_en && mode_q && (hr_idx == RXQ_IDX) && !rxq_empty;
        st_rx_en   = rx_push && !(mode_q && (rx_idx >= TXQ_IDX));
        st_ctl_we  = ctl_we && !(mode_q && (ctl_idx >= TXQ_IDX));
    end

    can_mbox_store #(
        .NUM_MB   (NUM_MB),
        .CLR_BASE (TXQ_BASE)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt         (fmt_q),
        .wr_en       (st_wr_en),
        .wr_idx      (hw_idx),
        .wr_frame    (frame_t'(hw_frame)),
        .rx_en       (st_rx_en),
        .rx_idx      (rx_idx),
        .rx_frame    (rx_f),
        .ctl_we      (st_ctl_we),
        .ctl_widx    (ctl_idx),
        .ctl_wdata   (mb_ctl_t'(ctl_wdata)),
        .clear_upper (enter_fifo),
        .rd_idx      (hr_idx),
        .rd_frame    (st_rd_frame),
        .ctl_ridx    (ctl_ridx),
        .ctl_rdata   (st_ctl_rdata)
    );

    can_mbox_queue #(
        .W     (FRAME_W),
        .DEPTH (QDEPTH)
    ) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (txq_push),
        .din   (hw_frame),
        .pop   (txq_pop_ok),
        .dout  (txq_head),
        .full  (txq_full),
        .empty (txq_empty)
    );

    can_mbox_queue #(
        .W     (FRAME_W),
        .DEPTH (QDEPTH)
    ) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rxq_push),
        .din   (rx_frame),
        .pop   (rxq_pop),
        .dout  (rxq_head),
        .full  (rxq_full),
        .empty (rxq_empty)
    );

    // Host read mux with window handling and format-dependent IDE
    always_comb begin
        if (mode_q && (hr_idx == RXQ_IDX)) begin
            hr_frame = rxq_empty ? '0 : apply_fmt(rxq_head, fmt_q);
        end else if (mode_q && (hr_idx >= TXQ_IDX)) begin
            hr_frame = '0;
        end else begin
            hr_frame = apply_fmt(st_rd_frame, fmt_q);
        end
        ctl_rdata = (mode_q && (ctl_ridx >= TXQ_IDX)) ? '0 : st_ctl_rdata;
        txq_valid = !txq_empty;
        txq_frame = txq_empty ? '0 : apply_fmt(txq_head, fmt_q);
        mode_o    = mode_q;
        id_fmt_o  = fmt_q;
    end

    // Sticky transmit overflow, cleared by an accepted configuration write
    always_ff @(posedge clk) begin
        if (!rst_n)                    txq_ovf <= 1'b0;
        else if (txq_try && txq_full)  txq_ovf <= 1'b1;
        else if (cfg_ok)               txq_ovf <= 1'b0;
    end

    // Saturating count of frames dropped at a full receive queue
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rx_overrun_cnt <= '0;
        else if (rxq_drop && (rx_overrun_cnt != '1)) rx_overrun_cnt <= rx_overrun_cnt + 1'b1;
    end

endmodule

// File: rtl/can_mbox_bank_sva.sv
// Property checker for the mailbox bank, attached to every instance of
// the top by the bind below. Observes ports only.
module can_mbox_bank_sva #(
    parameter int NUM_MB = 32,
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_fifo_mode,
    input logic [1:0]       cfg_id_fmt,
    input logic             mode_o,
    input logic [1:0]       id_fmt_o,
    input logic             cfg_err_o,
    input logic             hw_en,
    input logic [IDX_W-1:0] hw_idx,
    input logic             txq_full,
    input logic             txq_empty,
    input logic             txq_ovf,
    input logic             rxq_full,
    input logic             rxq_empty,
    input logic [CNT_W-1:0] rx_overrun_cnt
);

    localparam logic [IDX_W-1:0] TXQ_IDX = IDX_W'(NUM_MB - 2 * QDEPTH);

    p_fmt_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        id_fmt_o != 2'b11);

    p_fmt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_id_fmt == 2'b11) |=> ($stable(id_fmt_o) && $stable(mode_o) && cfg_err_o));

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_fifo_mode != mode_o) && !(txq_empty && rxq_empty))
            |=> ($stable(mode_o) && cfg_err_o));

    p_mode_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> (txq_empty && rxq_empty));

    p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(txq_full && txq_empty) && !(rxq_full && rxq_empty));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o && txq_full && hw_en && (hw_idx == TXQ_IDX)) |=> txq_ovf);

    p_overrun_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_overrun_cnt) |-> (rx_overrun_cnt == $past(rx_overrun_cnt) + 1'b1));

endmodule

bind can_mbox_bank can_mbox_bank_sva #(
    .NUM_MB (NUM_MB),
    .QDEPTH (QDEPTH),
    .CNT_W  (CNT_W)
) u_sva (.*);

// File: tb/can_mbox_bank_bench.sv
`timescale 1ns/1ps
module can_mbox_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_fifo_mode = 0, cfg_rxq_ide = 0;
    logic [1:0]  cfg_id_fmt = 0;
    logic        mode_o, cfg_err_o;
    logic [1:0]  id_fmt_o;
    logic        hw_en = 0, hr_en = 0, ctl_we = 0, rx_push = 0, txq_pop = 0;
    logic [4:0]  hw_idx = 0, hr_idx = 0, ctl_idx = 0, ctl_ridx = 0, rx_idx = 0;
    logic [98:0] hw_frame = 0, rx_frame = 0, hr_frame, txq_frame;
    logic [2:0]  ctl_wdata = 0, ctl_rdata;
    logic [7:0]  rx_overrun_cnt;
    logic        txq_valid, txq_full, txq_empty, txq_ovf, rxq_full, rxq_empty;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    can_mbox_bank u_can_mbox_bank (.*);

    // Vector fields: {index[4:0], format[1:0], written IDE, expected IDE}
    localparam logic [8:0] VEC [6] = '{
        9'b00101_00_0_0, 9'b11000_00_1_0, 9'b11100_01_0_1,
        9'b11111_01_1_1, 9'b00000_10_0_0, 9'b10001_10_1_1
    };

    function automatic logic [98:0] mkf(input logic ide, input logic rtr,
                                        input logic [28:0] id, input logic [3:0] dlc,
                                        input logic [63:0] data);
        return {ide, rtr, id, dlc, data};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [98:0] act, input logic [98:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cfg(input logic m, input logic [1:0] f, input logic ri);
        cfg_we = 1; cfg_fifo_mode = m; cfg_id_fmt = f; cfg_rxq_ide = ri;
        step();
        cfg_we = 0;
    endtask

    task automatic host_wr(input logic [4:0] idx, input logic [98:0] fr);
        hw_en = 1; hw_idx = idx; hw_frame = fr;
        step();
        hw_en = 0;
    endtask

    task automatic ctl_wr(input logic [4:0] idx, input logic [2:0] v);
        ctl_we = 1; ctl_idx = idx; ctl_wdata = v;
        step();
        ctl_we = 0;
    endtask

    task automatic rx_in(input logic [4:0] idx, input logic [98:0] fr);
        rx_push = 1; rx_idx = idx; rx_frame = fr;
        step();
        rx_push = 0;
    endtask

    task automatic tx_take();
        txq_pop = 1;
        step();
        txq_pop = 0;
    endtask

    task automatic rx_take();
        hr_idx = 5'd28; hr_en = 1;
        step();
        hr_en = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    logic [98:0] tq [8];
    logic [98:0] rq [5];
    logic [98:0] fa, fb, fc, fd;

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();

        // R1: reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 fmt", id_fmt_o, 0);
        chk("R1 err", cfg_err_o, 0);
        chk("R1 tx flags", {txq_valid, txq_full, txq_empty, txq_ovf}, 4'b0010);
        chk("R1 rx flags", {rxq_full, rxq_empty}, 2'b01);
        chk("R1 overrun", rx_overrun_cnt, 0);

        // R2 and R9: table of flat-layout writes under each format
        for (int v = 0; v < 6; v++) begin
            logic [98:0] fr;
            fr = mkf(VEC[v][1], 1'b0, 29'(v * 1000 + 5), 4'(v + 1), 64'hA5A5_0000_0000_0000 | 64'(v));
            do_cfg(1'b0, VEC[v][3:2], 1'b0);
            host_wr(VEC[v][8:4], fr);
            hr_idx = VEC[v][8:4];
            #1;
            chk("R2/R9 table", hr_frame, {VEC[v][0], fr[97:0]});
        end

        // R13 and R10: flat receive gated by control word and IDE
        do_cfg(1'b0, 2'b10, 1'b0);
        fa = mkf(0, 0, 29'h11, 4'd2, 64'h1111);
        fb = mkf(0, 0, 29'h22, 4'd2, 64'h2222);
        fc = mkf(1, 0, 29'h33, 4'd2, 64'h3333);
        fd = mkf(0, 1, 29'h44, 4'd0, 64'h0);
        ctl_wr(5'd7, 3'b001);
        host_wr(5'd7, mkf(0, 0, 29'h1, 4'd1, 64'h1));
        rx_in(5'd7, fa);
        hr_idx = 5'd7; #1;
        chk("R13 enabled rx stored", hr_frame, fa);
        ctl_wr(5'd7, 3'b011);
        rx_in(5'd7, fb);
        chk("R13 tx-direction mailbox ignores rx", hr_frame, fa);
        ctl_wr(5'd7, 3'b001);
        rx_in(5'd7, fc);
        chk("R10 IDE mismatch dropped", hr_frame, fa);
        rx_in(5'd7, fd);
        chk("R13 second rx stored", hr_frame, fd);

        // R11: control words of the upper mailboxes
        ctl_wr(5'd26, 3'b111);
        ctl_ridx = 5'd26; #1;
        chk("R11 flat ctl write", ctl_rdata, 3'b111);
        do_cfg(1'b1, 2'b10, 1'b1);
        chk("R8 enter queue layout", mode_o, 1);
        chk("R11 queue ctl read zero", ctl_rdata, 0);
        ctl_wr(5'd26, 3'b101);
        chk("R11 queue ctl write ignored", ctl_rdata, 0);
        ctl_wr(5'd3, 3'b101);
        ctl_ridx = 5'd3; #1;
        chk("R11 lower ctl still writable", ctl_rdata, 3'b101);
        do_cfg(1'b0, 2'b10, 1'b1);
        ctl_ridx = 5'd26; #1;
        chk("R11 upper ctl cleared on entry", ctl_rdata, 0);
        do_cfg(1'b1, 2'b10, 1'b1);

        // R3, R5, R12: transmit queue fill, overflow, order and wraparound
        for (int k = 0; k < 8; k++)
            tq[k] = mkf(k[0] ^ 1'b1, (k == 1) || (k == 6), 29'(16'hC000 + k), 4'(k), 64'(k) << 8);
        for (int k = 0; k < 4; k++) host_wr(5'd24, tq[k]);
        chk("R5 tx full", {txq_full, txq_empty, txq_valid}, 3'b101);
        chk("R3 tx head", txq_frame, tq[0]);
        hr_idx = 5'd24; #1;
        chk("R3 window read zero", hr_frame, 0);
        host_wr(5'd24, tq[4]);
        chk("R5 overflow flag", txq_ovf, 1);
        chk("R5 still full", txq_full, 1);
        for (int k = 0; k < 4; k++) begin
            chk("R3/R12 tx order", txq_frame, tq[k]);
            tx_take();
        end
        chk("R5 tx empty", {txq_full, txq_empty, txq_valid}, 3'b010);
        chk("R3 empty head zero", txq_frame, 0);
        for (int k = 5; k < 8; k++) host_wr(5'd24, tq[k]);
        do_cfg(1'b1, 2'b00, 1'b1);
        chk("R9 queue IDE under standard", txq_frame, {1'b0, tq[5][97:0]});
        chk("R5 ovf cleared by cfg", txq_ovf, 0);
        do_cfg(1'b1, 2'b10, 1'b1);
        for (int k = 5; k < 8; k++) begin
            chk("R3/R12 tx wrap order", txq_frame, tq[k]);
            tx_take();
        end
        chk("R3 tx drained", txq_empty, 1);

        // R4, R6, R10, R12: receive queue
        for (int k = 0; k < 5; k++)
            rq[k] = mkf(1, k == 1, 29'(16'hD000 + k), 4'(8 - k), 64'hBEEF_0000 + 64'(k));
        rx_in(5'd28, rq[0]);
        rx_in(5'd30, rq[1]);
        rx_in(5'd29, mkf(0, 0, 29'h5, 4'd1, 64'h5));
        rx_in(5'd31, rq[2]);
        rx_in(5'd28, rq[3]);
        chk("R4 rx full", {rxq_full, rxq_empty}, 2'b10);
        rx_in(5'd28, rq[4]);
        chk("R6 overrun count", rx_overrun_cnt, 1);
        for (int k = 0; k < 4; k++) begin
            hr_idx = 5'd28; #1;
            chk("R4/R10/R12 rx order", hr_frame, rq[k]);
            rx_take();
        end
        chk("R4 rx empty", {rxq_full, rxq_empty}, 2'b01);
        chk("R4 empty window zero", hr_frame, 0);
        do_cfg(1'b1, 2'b00, 1'b0);
        rx_in(5'd28, rq[0]);
        chk("R10 standard rejects IDE 1", rxq_empty, 1);
        rx_in(5'd28, fa);
        chk("R10 standard accepts IDE 0", hr_frame, fa);
        rx_take();
        chk("R4 popped", rxq_empty, 1);

        // R8: layout change refused while a queue holds data
        do_cfg(1'b1, 2'b10, 1'b1);
        host_wr(5'd24, tq[0]);
        do_cfg(1'b0, 2'b10, 1'b1);
        chk("R8 change refused", {mode_o, cfg_err_o}, 2'b11);
        tx_take();
        do_cfg(1'b0, 2'b10, 1'b1);
        chk("R8 change accepted", {mode_o, cfg_err_o}, 2'b00);

        // R7: forbidden format code
        do_cfg(1'b0, 2'b11, 1'b0);
        chk("R7 format held", id_fmt_o, 2'b10);
        chk("R7 error set", cfg_err_o, 1);
        do_cfg(1'b0, 2'b01, 1'b0);
        chk("R7 legal write", {id_fmt_o, cfg_err_o}, 3'b010);

        finish_run();
    end

endmodule